// File: doc/BRIEF.md
# Two-Phase Scan Chain Host Sequencer

This block runs off the system clock and drives a serial scan chain built from master/slave latch pairs. The chain is clocked by two separate strobes that never overlap. The host issues one of three commands through a start/busy/done handshake.

- **Rotate** pushes the low bits of a parallel write vector into the chain one at a time. In the same pass it collects the bits that leave the chain into a parallel read vector.
- **Capture** makes the chain sample the chip's values with a single strobe pair.
- **Update** pulses the chain's output latches so the chip sees the newly shifted contents.

The strobe width and the gaps between strobes are programmable in system clock cycles. This lets the same block drive slow off-chip wiring or fast on-chip wiring.

A write is a rotate followed by an update. A read is a capture followed by a rotate, after which the read vector holds the captured values.

Top module: `scan_sequencer`

## Requirements
- R1: After reset, `scan_phi`, `scan_phi_n`, `scan_upd`, `scan_cap`, `scan_din`, `busy`, `done` and `rdata` are all 0.
- R2: Each strobe pair has four phases, in this order. First, `scan_din` is held for G cycles with both strobes low. Then `scan_phi` is high for W cycles. Then both strobes are low for G cycles. Then `scan_phi_n` is high for W cycles. The two strobes are never high together.
- R3: A rotate of N bits (`cmd`=2'b00) issues exactly N strobe pairs. During pair j (0-based), `scan_din` carries `wdata[N-1-j]`, so the highest selected bit goes first. N above CHAIN_LEN is clamped to CHAIN_LEN. After the last pair, G idle cycles follow with `scan_din` at 0.
- R4: During a rotate, `scan_dout` is sampled on the last setup cycle before each `scan_phi` rise, which is after the previous `scan_phi_n` fell. The bit sampled before pair j goes to `rdata[N-1-j]`. `rdata` bits at index N and above keep their values.
- R5: A capture (`cmd`=2'b10) raises `scan_cap` G cycles before `scan_phi` rises and issues exactly one strobe pair. `scan_cap` stays high for G cycles after `scan_phi_n` falls, and `scan_din` stays 0 throughout.
- R6: An update (`cmd`=2'b01) holds `scan_upd` high for W cycles and then waits G cycles. Neither strobe rises during an update.
- R7: A pulse width or gap input of 0 is treated as 1.
- R8: `start` is ignored while `busy` is high, and `cmd`=2'b11 is ignored in every state. The operands are latched at start, so changes to them during a command have no effect.
- R9: `busy` rises the cycle after an accepted start. `done` is high for exactly one cycle, in the first cycle with `busy` low after a command. A rotate or capture keeps `busy` high for N*(2G+2W)+G cycles (N=1 for a capture), and an update for W+G cycles.
- R10: A rotate with N=0 issues no strobes and finishes after G cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Command request, taken when idle |
| cmd | input | 2 | 00 rotate, 01 update, 10 capture, 11 none |
| nbits | input | $clog2(CHAIN_LEN+1) | Bits to rotate |
| pulse_w | input | CNT_W | Strobe width in cycles |
| gap_w | input | CNT_W | Setup/gap/hold in cycles |
| wdata | input | CHAIN_LEN | Write vector |
| rdata | output | CHAIN_LEN | Read vector |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| scan_din | output | 1 | Serial data to chain |
| scan_dout | input | 1 | Serial data from chain |
| scan_phi | output | 1 | Master latch strobe |
| scan_phi_n | output | 1 | Slave latch strobe |
| scan_upd | output | 1 | Chip output latch strobe |
| scan_cap | output | 1 | Chain capture select |

## Verification
The bench runs a behavioural latch-pair chain and compares every output against a reference timeline on every clock. It covers the following corner cases:
- **Zero width and gap (R7).** A design that decodes a count of zero literally would either wrap its counter and stall for hundreds of cycles, or collapse the gap so the two strobes touch.
- **A zero-length rotate (R10).** A design that tests the bit count only after the first strobe would emit a stray strobe pair.
- **Rotates shorter than the register.** These check that untouched read bits survive (R4).
- **A request issued mid-command, alongside changes to the write vector (R8).** A design that does not latch its operands would splice the new data into the shifted stream.
- **Round trips through the chain model.** A write followed by an update, and a capture followed by a read, expose reversed bit order or a read sampled one shift late.

// File: rtl/scan_sequencer.sv
module scan_sequencer #(
  parameter int CHAIN_LEN = 16,
  parameter int CNT_W     = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic [1:0]                     cmd,
  input  logic [$clog2(CHAIN_LEN+1)-1:0] nbits,
  input  logic [CNT_W-1:0]               pulse_w,
  input  logic [CNT_W-1:0]               gap_w,
  input  logic [CHAIN_LEN-1:0]           wdata,
  output logic [CHAIN_LEN-1:0]           rdata,
  output logic                           busy,
  output logic                           done,
  output logic                           scan_din,
  input  logic                           scan_dout,
  output logic                           scan_phi,
  output logic                           scan_phi_n,
  output logic                           scan_upd,
  output logic                           scan_cap
);
  localparam int NB_W  = $clog2(CHAIN_LEN+1);
  localparam int IDX_W = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
  localparam logic [CNT_W-1:0] C1 = CNT_W'(1);
  localparam logic [NB_W-1:0]  N1 = NB_W'(1);
  localparam int S_IDLE = 0, S_SET = 1, S_PHI = 2, S_MID = 3,
                 S_PHB = 4, S_TAIL = 5, S_UPD = 6, S_POST = 7;
  localparam logic [1:0] CMD_ROT = 2'b00, CMD_UPD = 2'b01, CMD_CAP = 2'b10;

  logic [7:0]           st;
  logic [CNT_W-1:0]     cnt, wv, gv;
  logic [NB_W-1:0]      nb;
  logic [IDX_W-1:0]     idx;
  logic [CHAIN_LEN-1:0] wd;
  logic                 is_rot;

  wire [CNT_W-1:0] w_in   = (pulse_w == '0) ? C1 : pulse_w;
  wire [CNT_W-1:0] g_in   = (gap_w == '0) ? C1 : gap_w;
  wire [NB_W-1:0]  n_in   = (nbits > NB_W'(CHAIN_LEN)) ? NB_W'(CHAIN_LEN) : nbits;
  wire [IDX_W-1:0] n_top  = IDX_W'(n_in - N1);
  wire [IDX_W-1:0] idx_dn = idx - IDX_W'(1);
  wire             w_end  = (cnt == wv - C1);
  wire             g_end  = (cnt == gv - C1);

  assign busy       = !st[S_IDLE];
  assign scan_phi   = st[S_PHI];
  assign scan_phi_n = st[S_PHB];
  assign scan_upd   = st[S_UPD];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= 8'b1 << S_IDLE;
      cnt      <= '0;
      wv       <= C1;
      gv       <= C1;
      nb       <= '0;
      idx      <= '0;
      wd       <= '0;
      is_rot   <= 1'b0;
      rdata    <= '0;
      done     <= 1'b0;
      scan_din <= 1'b0;
      scan_cap <= 1'b0;
    end else begin
      done <= 1'b0;
      cnt  <= cnt + C1;
      unique case (1'b1)
        st[S_IDLE]: begin
          cnt <= '0;
          if (start && cmd != 2'b11) begin
            wv <= w_in;
            gv <= g_in;
            if (cmd == CMD_ROT) begin
              is_rot   <= 1'b1;
              wd       <= wdata;
              nb       <= n_in;
              idx      <= n_top;
              scan_din <= (n_in != '0) ? wdata[n_top] : 1'b0;
              st       <= (n_in != '0) ? 8'b1 << S_SET : 8'b1 << S_TAIL;
            end else if (cmd == CMD_CAP) begin
              scan_cap <= 1'b1;
              nb       <= N1;
              idx      <= '0;
              st       <= 8'b1 << S_SET;
            end else begin
              st <= 8'b1 << S_UPD;
            end
          end
        end
        st[S_SET]: if (g_end) begin
          if (is_rot) rdata[idx] <= scan_dout;
          cnt <= '0;
          st  <= 8'b1 << S_PHI;
        end
        st[S_PHI]: if (w_end) begin
          cnt <= '0;
          st  <= 8'b1 << S_MID;
        end
        st[S_MID]: if (g_end) begin
          cnt <= '0;
          st  <= 8'b1 << S_PHB;
        end
        st[S_PHB]: if (w_end) begin
          cnt <= '0;
          if (nb == N1) begin
            scan_din <= 1'b0;
            st       <= 8'b1 << S_TAIL;
          end else begin
            nb       <= nb - N1;
            idx      <= idx_dn;
            scan_din <= wd[idx_dn];
            st       <= 8'b1 << S_SET;
          end
        end
        st[S_TAIL]: if (g_end) begin
          cnt      <= '0;
          done     <= 1'b1;
          is_rot   <= 1'b0;
          scan_cap <= 1'b0;
          st       <= 8'b1 << S_IDLE;
        end
        st[S_UPD]: if (w_end) begin
          cnt <= '0;
          st  <= 8'b1 << S_POST;
        end
        st[S_POST]: if (g_end) begin
          cnt  <= '0;
          done <= 1'b1;
          st   <= 8'b1 << S_IDLE;
        end
        default: st <= 8'b1 << S_IDLE;
      endcase
    end
  end
endmodule

module scan_sequencer_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic scan_din,
  input logic scan_phi,
  input logic scan_phi_n,
  input logic scan_upd,
  input logic scan_cap
);
  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(scan_phi && scan_phi_n));
  a_r2_din_held: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_phi || scan_phi_n) |-> $stable(scan_din));
  a_r2_phi_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scan_phi) |-> !$past(scan_phi_n));
  a_r5_cap_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_phi || scan_phi_n) |-> $stable(scan_cap));
  a_r6_upd_alone: assert property (@(posedge clk) disable iff (!rst_n)
    scan_upd |-> !scan_phi && !scan_phi_n && !scan_cap);
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !scan_phi && !scan_phi_n && !scan_upd && !scan_cap);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));
endmodule

bind scan_sequencer scan_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .scan_din(scan_din),
  .scan_phi(scan_phi), .scan_phi_n(scan_phi_n), .scan_upd(scan_upd),
  .scan_cap(scan_cap)
);

// File: tb/test_scan_sequencer.sv
module test_scan_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int CL = 16;

  logic clk = 0, rst_n = 0, start = 0;
  logic [1:0] cmd = 0;
  logic [4:0] nbits = 0;
  logic [7:0] pulse_w = 1, gap_w = 1;
  logic [CL-1:0] wdata = 0, rdata;
  logic busy, done, scan_din, scan_dout, scan_phi, scan_phi_n, scan_upd, scan_cap;

  int checks = 0, fails = 0;

  // behavioural chain model
  int mlen = 8;
  logic [CL-1:0] chain = 0, mst = 0, capv = 0, chip_out = 0;
  assign scan_dout = chain[mlen-1];
  always @(posedge scan_phi) mst = scan_cap ? capv : {chain[CL-2:0], scan_din};
  always @(negedge scan_phi_n) chain = mst;
  always @(negedge scan_upd) chip_out = chain;

  always #(CLK_PERIOD/2) clk = ~clk;

  scan_sequencer i_scan_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .nbits(nbits),
    .pulse_w(pulse_w), .gap_w(gap_w), .wdata(wdata), .rdata(rdata),
    .busy(busy), .done(done), .scan_din(scan_din), .scan_dout(scan_dout),
    .scan_phi(scan_phi), .scan_phi_n(scan_phi_n), .scan_upd(scan_upd),
    .scan_cap(scan_cap));

  task automatic check(string tag, logic [CL-1:0] got, logic [CL-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // {phi, phi_n, upd, cap, din, busy, done}
  function automatic logic [6:0] expect_at(int k, logic [1:0] c, int n, int w, int g,
                                           logic [CL-1:0] wd);
    int p = 2*g + 2*w;
    int t = (c == 2'b01) ? w + g : n*p + g;
    logic [6:0] e = '0;
    if (k == t + 1) e[0] = 1'b1;
    if (k > t) return e;
    e[1] = 1'b1;
    if (c == 2'b01) begin
      e[4] = (k <= w);
      return e;
    end
    e[3] = (c == 2'b10);
    if (k <= n*p) begin
      int j = (k-1) / p;
      int o = (k-1) % p;
      e[6] = (o >= g) && (o < g + w);
      e[5] = (o >= 2*g + w);
      if (c == 2'b00) e[2] = wd[n-1-j];
    end
    return e;
  endfunction

  task automatic run(logic [1:0] c, int n, int w, int g, logic [CL-1:0] wd,
                     bit interfere);
    int we = (w == 0) ? 1 : w;
    int ge = (g == 0) ? 1 : g;
    int ne = (c == 2'b10) ? 1 : ((n > CL) ? CL : n);
    int t = (c == 2'b01) ? we + ge : ne*(2*ge + 2*we) + ge;
    @(negedge clk);
    cmd = c; nbits = 5'(n); pulse_w = 8'(w); gap_w = 8'(g); wdata = wd; start = 1;
    @(negedge clk);
    start = 0;
    for (int k = 1; k <= t + 2; k++) begin
      logic [6:0] got = {scan_phi, scan_phi_n, scan_din, scan_upd, scan_cap, busy, done};
      logic [6:0] ex = expect_at(k, c, ne, we, ge, wd);
      logic [6:0] exo = {ex[6], ex[5], ex[2], ex[4], ex[3], ex[1], ex[0]};
      check($sformatf("R2/R3/R5/R6/R9 cmd %b k=%0d {phi,phin,din,upd,cap,busy,done}", c, k),
            CL'(got), CL'(exo));
      if (interfere && k == 3) begin
        start = 1; cmd = 2'b01; wdata = ~wd; nbits = 5'd1; pulse_w = 8'd9;
      end
      if (interfere && k == 4) start = 0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", CL'({scan_phi, scan_phi_n, scan_upd, scan_cap, scan_din, busy, done}), '0);
    check("R1 reset rdata", rdata, '0);
    rst_n = 1;

    // write: rotate then update (R3, R6)
    mlen = 8;
    run(2'b00, 8, 2, 1, 16'hA5C3, 0);
    check("R4 initial chain read", rdata, 16'h0000);
    run(2'b01, 0, 2, 1, '0, 0);
    check("R3 written chain bit order", {8'h00, chip_out[7:0]}, 16'h00C3);

    // read: capture then rotate (R5, R4)
    capv = 16'h3C96;
    run(2'b10, 0, 1, 2, '0, 0);
    run(2'b00, 8, 1, 2, 16'h0F0F, 0);
    check("R4 captured data read back, upper bits kept", rdata, 16'h0096);

    // full length with zero width/gap (R7)
    mlen = 16; capv = 16'hBEEF;
    run(2'b10, 0, 0, 0, '0, 0);
    run(2'b00, 16, 0, 0, 16'h1234, 0);
    check("R7 full read with zero timing", rdata, 16'hBEEF);
    run(2'b01, 0, 0, 0, '0, 0);
    check("R7 full write with zero timing", chip_out, 16'h1234);

    // clamp above chain length (R3)
    run(2'b00, 20, 1, 1, 16'h8001, 0);
    check("R3 clamped rotate reads previous contents", rdata, 16'h1234);

    // zero-length rotate (R10)
    run(2'b00, 0, 3, 2, 16'hFFFF, 0);
    check("R10 zero rotate leaves rdata", rdata, 16'h1234);

    // busy interference (R8)
    run(2'b00, 4, 2, 2, 16'h000A, 1);
    check("R8 no extra command after interference", CL'({busy, done}), '0);

    // ignored command code (R8)
    @(negedge clk);
    cmd = 2'b11; start = 1;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 4; i++) begin
      check("R8 cmd 11 ignored", CL'({busy, done, scan_phi, scan_upd, scan_cap}), '0);
      @(negedge clk);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule